// File: doc/BRIEF.md
# Recirculating Pattern Launcher

The block is a chain of single-bit cells that a tester fills serially and then sets running as a closed loop. Each cell is a flip-flop whose input comes through a two-way mux: one leg takes the serial shift path and the other takes the recirculation path. While the mode input is low, a bit stream from an external tester shifts into cell 0 and moves one cell further down the chain on every clock. When the mode input is high, the active part of the chain closes into a ring and the stored pattern circulates indefinitely. A small number of output lanes carries the pattern in parallel.

A depth value from outside selects how many cells form the ring, and therefore the repeat period of the pattern. Cells past the depth keep their contents while the ring runs. The lanes are taken from the two cells nearest the serial entry point, so the lanes carry the same sequence offset by one cycle. A serial tap shows the last active cell, which lets a tester read the chain back out. The tap is also the value that re-enters cell 0.

Top module: `pattern_launcher`

## Requirements
- R1: A synchronous reset clears every cell to 0 at the clock edge, whatever the mode and depth inputs are, so that after the edge all lanes and the tap read 0.
- R2: With `fire_i` = 0 (load mode), every clock edge moves `sdi_i` into cell 0 and moves cell k-1 into cell k for all cells of the chain, regardless of the depth setting.
- R3: With `fire_i` = 1 (fire mode) and an effective depth D, cell 0 takes the value of cell D-1 and cell k takes the value of cell k-1 for 1 ≤ k < D, so the lanes and the tap repeat with a period of D cycles.
- R4: In fire mode, every cell whose index is D or higher keeps its value unchanged.
- R5: `depth_i` is a 5-bit unsigned count of active cells. Values 0 and 1 act as 2, and values above 16 act as 16.
- R6: Lane k (`lane_o[k]`) shows cell k. `lane_o[0]` is the cell that was loaded most recently, and `lane_o[1]` equals the value `lane_o[0]` had one cycle earlier.
- R7: `tap_o` shows cell D-1 for the effective depth D applied at that moment, in both modes.
- R8: A change of `fire_i` takes effect at the next clock edge, and the cell contents are carried across the switch without being cleared.
- R9: A change of `depth_i` while firing takes effect at the next clock edge and loses no cell contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all cells update on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sdi_i | input | 1 | Serial data from the tester, used in load mode |
| fire_i | input | 1 | Mode select: 0 = load (shift), 1 = fire (recirculate) |
| depth_i | input | 5 | Requested number of active cells in the ring |
| lane_o | output | 2 | Parallel lanes: cell 0 and cell 1 |
| tap_o | output | 1 | Serial tap: last active cell |

## Verification
The bench first fills the chain and then fires it at the full depth and at several shorter depths. A feedback path taken from a fixed cell, rather than from the selected one, would show the wrong repeat period on the lanes. After a run at depth 5, the bench shifts the whole chain out through the tap at full depth. This exposes any cell past the depth that was not held, and any cell that was wiped when the mode switched. Depth values of 0, 1, 20 and 31 check the clamp: a design without it would select a nonexistent cell or a one-cell ring, and the tap would read constant or wrong values. A reset applied in the middle of a fire run must clear the ring even though the mode input stays high.

// File: rtl/lpl_pkg.sv
package lpl_pkg;

   // Operating mode of the chain, taken from the mode input pin.
   typedef enum logic {
      MODE_LOAD = 1'b0,
      MODE_FIRE = 1'b1
   } launch_mode_e;

   // Structural choice for the tap multiplexer.
   typedef enum logic {
      TAP_ONEHOT  = 1'b0,
      TAP_INDEXED = 1'b1
   } tap_style_e;

endpackage

// File: rtl/lpl_depth_decode.sv
module lpl_depth_decode #(
   parameter int unsigned CHAIN_LEN = 16,
   parameter int unsigned MIN_DEPTH = 2,
   localparam int unsigned DEPTH_W  = $clog2(CHAIN_LEN + 1),
   localparam int unsigned IDX_W    = $clog2(CHAIN_LEN)
) (
   input  logic [DEPTH_W-1:0]   depth_i,
   output logic [CHAIN_LEN-1:0] active_o,
   output logic [IDX_W-1:0]     last_idx_o
);

   logic [DEPTH_W-1:0] eff_depth;

   // Clamp the requested depth into the legal window.
   always_comb begin
      if (depth_i < DEPTH_W'(MIN_DEPTH)) begin
         eff_depth = DEPTH_W'(MIN_DEPTH);
      end else if (depth_i > DEPTH_W'(CHAIN_LEN)) begin
         eff_depth = DEPTH_W'(CHAIN_LEN);
      end else begin
         eff_depth = depth_i;
      end
   end

   logic [DEPTH_W-1:0] last_full;
   assign last_full  = eff_depth - 1'b1;
   assign last_idx_o = last_full[IDX_W-1:0];

   // Thermometer mask of the cells that take part in the ring.
   for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_mask
      assign active_o[c] = (eff_depth > DEPTH_W'(c));
   end

endmodule

// File: rtl/lpl_cell.sv
module lpl_cell (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic loop_sel_i,
   input  logic shift_d_i,
   input  logic loop_d_i,
   output logic q_o
);

   logic next_d;

   // Two-way input mux: serial shift leg or recirculation leg.
   assign next_d = loop_sel_i ? loop_d_i : shift_d_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         q_o <= 1'b0;
      end else if (en_i) begin
         q_o <= next_d;
      end
   end

endmodule

// File: rtl/lpl_tap_select.sv
module lpl_tap_select #(
   parameter int unsigned        CHAIN_LEN = 16,
   parameter lpl_pkg::tap_style_e TAP_STYLE = lpl_pkg::TAP_ONEHOT,
   localparam int unsigned       IDX_W     = $clog2(CHAIN_LEN)
) (
   input  logic [CHAIN_LEN-1:0] cells_i,
   input  logic [IDX_W-1:0]     last_idx_i,
   output logic                 tap_o
);

   if (TAP_STYLE == lpl_pkg::TAP_ONEHOT) begin : g_onehot
      // Flat AND-OR tree: shallow, with one decode term per cell.
      logic [CHAIN_LEN-1:0] hit;
      for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_hit
         assign hit[c] = cells_i[c] & (last_idx_i == IDX_W'(c));
      end
      assign tap_o = |hit;
   end else begin : g_indexed
      // Binary-indexed mux tree.
      assign tap_o = cells_i[last_idx_i];
   end

endmodule

// File: rtl/pattern_launcher.sv
module pattern_launcher #(
   parameter int unsigned         CHAIN_LEN = 16,
   parameter int unsigned         LANES     = 2,
   parameter int unsigned         MIN_DEPTH = 2,
   parameter lpl_pkg::tap_style_e TAP_STYLE = lpl_pkg::TAP_ONEHOT,
   localparam int unsigned        DEPTH_W   = $clog2(CHAIN_LEN + 1),
   localparam int unsigned        IDX_W     = $clog2(CHAIN_LEN)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               sdi_i,
   input  logic               fire_i,
   input  logic [DEPTH_W-1:0] depth_i,
   output logic [LANES-1:0]   lane_o,
   output logic               tap_o
);

   // Elaboration-time parameter checks.
   if (MIN_DEPTH < 2) begin : g_bad_min
      $error("pattern_launcher: MIN_DEPTH must be at least 2");
   end
   if (CHAIN_LEN < MIN_DEPTH) begin : g_bad_len
      $error("pattern_launcher: CHAIN_LEN must not be below MIN_DEPTH");
   end
   if (LANES < 1 || LANES > MIN_DEPTH) begin : g_bad_lanes
      $error("pattern_launcher: LANES must lie in 1..MIN_DEPTH");
   end

   lpl_pkg::launch_mode_e mode_w;
   assign mode_w = lpl_pkg::launch_mode_e'(fire_i);

   logic [CHAIN_LEN-1:0] chain_w;
   logic [CHAIN_LEN-1:0] active_w;
   logic [IDX_W-1:0]     last_idx_w;
   logic                 looping;

   assign looping = (mode_w == lpl_pkg::MODE_FIRE);

   lpl_depth_decode #(
      .CHAIN_LEN (CHAIN_LEN),
      .MIN_DEPTH (MIN_DEPTH)
   ) u_depth (
      .depth_i    (depth_i),
      .active_o   (active_w),
      .last_idx_o (last_idx_w)
   );

   lpl_tap_select #(
      .CHAIN_LEN (CHAIN_LEN),
      .TAP_STYLE (TAP_STYLE)
   ) u_tap (
      .cells_i    (chain_w),
      .last_idx_i (last_idx_w),
      .tap_o      (tap_o)
   );

   for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_cell
      logic shift_src;
      logic loop_src;
      if (c == 0) begin : g_head
         assign shift_src = sdi_i;
         assign loop_src  = tap_o;
      end else begin : g_body
         assign shift_src = chain_w[c-1];
         assign loop_src  = chain_w[c-1];
      end

      lpl_cell u_cell (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .en_i       (!looping || active_w[c]),
         .loop_sel_i (looping),
         .shift_d_i  (shift_src),
         .loop_d_i   (loop_src),
         .q_o        (chain_w[c])
      );

      // Cells past the ring must keep their value while firing.
      if (c >= MIN_DEPTH) begin : g_hold_chk
         assert_hold_outside_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            (fire_i && !active_w[c]) |=> $stable(chain_w[c]));
      end
   end

   assign lane_o = chain_w[LANES-1:0];

   // Load mode: the head cell captures the serial input.
   assert_load_head_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !fire_i |=> (chain_w[0] == $past(sdi_i)));

   // Fire mode: the head cell takes the tapped last active cell (R8: mode sampled at the edge).
   assert_loop_feedback_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      fire_i |=> (chain_w[0] == $past(tap_o)));

   // Depth clamp: the ring never falls below the minimum size.
   assert_depth_floor_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(active_w) >= MIN_DEPTH);

   // Depth clamp: an oversized request enables the whole chain.
   assert_depth_ceiling_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (depth_i >= DEPTH_W'(CHAIN_LEN)) |-> (&active_w));

   // Second lane trails the first by one cycle.
   if (LANES > 1) begin : g_lane_chk
      assert_lane_phase_R6: assert property (@(posedge clk_i) disable iff (rst_i)
         !rst_i |=> (lane_o[1] == $past(lane_o[0])));
   end

endmodule

// File: tb/pattern_launcher_tb_top.sv
module pattern_launcher_tb_top;

   localparam int CLEN = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sdi = 1'b0;
   logic       fire = 1'b0;
   logic [4:0] depth = 5'd16;
   logic [1:0] lane;
   logic       tap;

   always #4 clk = ~clk;

   pattern_launcher dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .sdi_i   (sdi),
      .fire_i  (fire),
      .depth_i (depth),
      .lane_o  (lane),
      .tap_o   (tap)
   );

   typedef struct {
      logic [1:0] lanes;
      logic       tap;
      string      tag;
   } exp_t;

   exp_t          sb_q[$];
   logic [CLEN-1:0] model = '0;
   int            checks = 0;
   int            errors = 0;
   bit            finished = 1'b0;

   function automatic int eff_depth(input int d);
      if (d < 2) return 2;
      if (d > CLEN) return CLEN;
      return d;
   endfunction

   // Driver: sets inputs at the falling edge and queues the result expected after the next rising edge.
   task automatic step(input logic r, input logic f, input logic s, input int d, input string tag);
      logic [CLEN-1:0] nxt;
      int de;
      exp_t e;
      @(negedge clk);
      rst = r; fire = f; sdi = s; depth = d[4:0];
      de = eff_depth(d);
      if (r) begin
         nxt = '0;
      end else if (!f) begin
         nxt = {model[CLEN-2:0], s};
      end else begin
         nxt = model;
         for (int k = 0; k < de; k++) begin
            nxt[k] = model[(k + de - 1) % de];
         end
      end
      model = nxt;
      e.lanes = model[1:0];
      e.tap   = model[de-1];
      e.tag   = tag;
      sb_q.push_back(e);
   endtask

   task automatic load_word(input logic [15:0] w, input int d, input string tag);
      for (int b = 15; b >= 0; b--) begin
         step(1'b0, 1'b0, w[b], d, tag);
      end
   endtask

   task automatic run_fire(input int n, input int d, input string tag);
      for (int i = 0; i < n; i++) begin
         step(1'b0, 1'b1, 1'b0, d, tag);
      end
   endtask

   // Monitor: compares outputs shortly after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (lane !== e.lanes || tap !== e.tap) begin
               errors++;
               $display("FAIL %s: lanes=%b tap=%b expected lanes=%b tap=%b",
                        e.tag, lane, tap, e.lanes, e.tap);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset with mode high still clears the chain.
      step(1'b1, 1'b1, 1'b1, 7, "R1");
      step(1'b1, 1'b1, 1'b1, 7, "R1");
      // R2: serial fill at full depth (tap also covers R7).
      load_word(16'hB4E1, 16, "R2");
      // R7: tap follows a shorter depth in load mode.
      load_word(16'h00A5, 3, "R7");
      load_word(16'hB4E1, 16, "R2");
      // R8: switch to fire keeps contents; R3: full-depth loop.
      step(1'b0, 1'b1, 1'b0, 16, "R8");
      run_fire(20, 16, "R3");
      // R9: depth change mid-run; R4: tail held.
      step(1'b0, 1'b1, 1'b0, 5, "R9");
      run_fire(12, 5, "R4");
      // R4/R8: shift everything out at full depth to expose the held tail.
      load_word(16'h0000, 16, "R4");
      // R6: walking one through the lanes.
      load_word(16'h0100, 16, "R6");
      // R5: depth clamp.
      load_word(16'h6C35, 16, "R5");
      run_fire(6, 0, "R5");
      run_fire(4, 1, "R5");
      run_fire(5, 31, "R5");
      run_fire(3, 20, "R5");
      // R3: odd depth period.
      run_fire(10, 7, "R3");
      // R1: reset during fire.
      step(1'b1, 1'b1, 1'b0, 7, "R1");
      run_fire(3, 7, "R1");
      repeat (3) @(posedge clk);
      #3;
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule